// File: doc/BRIEF.md
# Six-Stage 32-Bit Mixing Hash Pipeline

This block scrambles a 32-bit word through six fixed mixing rounds. Every round takes its input word and forms two terms from it: one is the word merged with a round constant (by addition or exclusive-or), the other is the word shifted by a fixed distance. The two terms are then merged into the round result by a second add or exclusive-or. All arithmetic wraps at 2^32. Each round ends in a pipeline register, so a new word can enter on every clock and its hash appears six clocks later, with a valid flag that travels alongside the data.

The output of every round is also brought out on a tap bus, with its own valid flag. This lets a checker compare intermediate round values against a software model, one round at a time. When no word enters, the registers keep their contents, so the taps and the output hold the last word that passed through them.

Top module: `mixhash6`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` low, every `tap_valid` bit low, and `out_word` and `tap_word` all zero.
- R2: `out_valid` equals the value `in_valid` had six clock edges earlier.
- R3: When `out_valid` is high, `out_word` is the full six-round hash of the word that entered six clock edges earlier.
- R4: Words presented on consecutive cycles, with no gap, all come out on consecutive cycles in the same order, each with its own correct hash.
- R5: Tap k (k = 0 for the first round, `tap_word` bits 32k+31 down to 32k, flag `tap_valid[k]`) holds the result of the first k+1 rounds applied to the word that entered k+1 clock edges earlier, with the flag copying that cycle's `in_valid`.
- R6: Round r computes J(C(x, K), S(x, n)) where both terms come from the round's own input x. In order of application: (1) C add 7ED55D16h, J add, left shift 12; (2) C xor C761C23Ch, J xor, right shift 19; (3) C add 165667B1h, J add, left shift 5; (4) C add D3A2646Ch, J xor, left shift 9; (5) C add FD7046C5h, J add, left shift 3; (6) C xor B55A4F09h, J xor, right shift 16. Shifts are logical. An input of zero gives 7ED55D16h after the first round.
- R7: A cycle with `in_valid` low advances the valid flags but leaves every round's data register unchanged, so `out_word` and each tap word keep their last captured value.
- R8: Every addition drops its carry out of bit 31; an input of FFFFFFFFh gives 7ED54D15h after the first round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as a word to hash this cycle |
| in_word | input | 32 | Word to be hashed |
| out_valid | output | 1 | Marks `out_word` as a finished hash |
| out_word | output | 32 | Six-round hash result |
| tap_valid | output | 6 | Valid flag of each round register, bit k for round k+1 |
| tap_word | output | 192 | Round register contents, round k+1 in bits 32k+31 down to 32k |

## Verification
On every cycle the assertions track the flag movement between round registers, the one-stage advance along the tap chain, the clearing on reset and the holding of data during bubbles. The arithmetic of each round, the ordering of the rounds and the modular wrap can only be shown by the scenarios, which compare the taps and the output with an independent model, including fixed literal values for zero and all-ones inputs, plus back-to-back bursts and bubble patterns.

// File: rtl/mixhash_pkg.sv
// Shared definitions for the six-round mixing hash.
// Holds the word width, the round count and the fixed round table.
// Assumes 32-bit words; the round constants are defined at that width.
package mixhash_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_ROUNDS = 6;
    localparam int SHAMT_W    = $clog2(WORD_W);
    localparam int TAP_W      = WORD_W * NUM_ROUNDS;

    // Two-input merge used both for the constant term and the final join.
    typedef enum logic {
        MERGE_ADD = 1'b0,
        MERGE_XOR = 1'b1
    } merge_op_e;

    // Direction of the shifted term.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    // Everything one round needs.
    typedef struct packed {
        logic [WORD_W-1:0]  konst;
        merge_op_e          konst_op;
        merge_op_e          join_op;
        shift_dir_e         dir;
        logic [SHAMT_W-1:0] amount;
    } round_cfg_t;

    // Round table, indexed from zero in order of application.
    function automatic round_cfg_t round_cfg(input int idx);
        round_cfg_t c;
        case (idx)
            0:       c = '{32'h7ED5_5D16, MERGE_ADD, MERGE_ADD, DIR_LEFT,  5'd12};
            1:       c = '{32'hC761_C23C, MERGE_XOR, MERGE_XOR, DIR_RIGHT, 5'd19};
            2:       c = '{32'h1656_67B1, MERGE_ADD, MERGE_ADD, DIR_LEFT,  5'd5};
            3:       c = '{32'hD3A2_646C, MERGE_ADD, MERGE_XOR, DIR_LEFT,  5'd9};
            4:       c = '{32'hFD70_46C5, MERGE_ADD, MERGE_ADD, DIR_LEFT,  5'd3};
            default: c = '{32'hB55A_4F09, MERGE_XOR, MERGE_XOR, DIR_RIGHT, 5'd16};
        endcase
        return c;
    endfunction

    // Wrapping add or bitwise xor of two words.
    function automatic logic [WORD_W-1:0] merge(input merge_op_e op,
                                                input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
        return (op == MERGE_XOR) ? (a ^ b) : (a + b);
    endfunction

endpackage

// File: rtl/mixhash_round_logic.sv
// Combinational datapath of one mixing round.
// Forms the constant term and the shifted term, both from the round's own
// input, and merges them with the round's join operator.
// Assumes ROUND_IDX selects a valid entry of the package round table.
module mixhash_round_logic
    import mixhash_pkg::*;
#(
    parameter int ROUND_IDX = 0
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);

    localparam round_cfg_t CFG = round_cfg(ROUND_IDX);

    logic [WORD_W-1:0] konst_term;
    logic [WORD_W-1:0] shift_term;

    // Constant term: input merged with the round constant.
    always_comb begin
        konst_term = merge(CFG.konst_op, word_in, CFG.konst);
    end

    // Shifted term: picked at elaboration by the round's direction.
    generate
        if (CFG.dir == DIR_RIGHT) begin : g_right
            always_comb shift_term = word_in >> CFG.amount;
        end else begin : g_left
            always_comb shift_term = word_in << CFG.amount;
        end
    endgenerate

    // Join of the two terms.
    always_comb begin
        word_out = merge(CFG.join_op, konst_term, shift_term);
    end

endmodule

// File: rtl/mixhash_round_reg.sv
// Pipeline register closing one round.
// The flag follows the input flag every cycle; the data only loads when the
// incoming flag is set, and otherwise holds. Synchronous active-low reset.
module mixhash_round_reg
    import mixhash_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q
);

    // Flag register: cleared in reset, otherwise copies the incoming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_in;
    end

    // Data register: cleared in reset, loads only on a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (valid_in) data_q <= data_in;
    end

    // R1: reset leaves the register empty and zeroed.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_q && data_q == '0));

    // R2: a valid word becomes a valid stage entry one edge later.
    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_q);

    // R2: a bubble stays a bubble.
    a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_q);

    // R7: bubbles do not disturb the stored data.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(data_q));

endmodule

// File: rtl/mixhash6.sv
// Six-round pipelined 32-bit mixing hash.
// Chains one combinational round and one register per round, accepts a word
// every cycle, and presents its hash six edges later. The register of each
// round is exposed on the tap bus for comparison against a model.
// Assumes the round table in mixhash_pkg.
module mixhash6
    import mixhash_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_word,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_word,
    output logic [NUM_ROUNDS-1:0] tap_valid,
    output logic [TAP_W-1:0]      tap_word
);

    localparam int LAST = NUM_ROUNDS - 1;

    logic [NUM_ROUNDS-1:0] stage_v_in;
    logic [WORD_W-1:0]     stage_d_in [NUM_ROUNDS];
    logic [WORD_W-1:0]     stage_mix  [NUM_ROUNDS];
    logic [NUM_ROUNDS-1:0] stage_v_q;
    logic [WORD_W-1:0]     stage_d_q  [NUM_ROUNDS];

    generate
        for (genvar r = 0; r < NUM_ROUNDS; r++) begin : g_round
            // Feed of round r: the block input or the previous register.
            if (r == 0) begin : g_head
                always_comb begin
                    stage_v_in[r] = in_valid;
                    stage_d_in[r] = in_word;
                end
            end else begin : g_link
                always_comb begin
                    stage_v_in[r] = stage_v_q[r-1];
                    stage_d_in[r] = stage_d_q[r-1];
                end
            end

            mixhash_round_logic #(
                .ROUND_IDX (r)
            ) u_logic (
                .word_in  (stage_d_in[r]),
                .word_out (stage_mix[r])
            );

            mixhash_round_reg #(
                .DATA_W (WORD_W)
            ) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid_in (stage_v_in[r]),
                .data_in  (stage_mix[r]),
                .valid_q  (stage_v_q[r]),
                .data_q   (stage_d_q[r])
            );

            // Tap slice of round r.
            always_comb begin
                tap_word[r*WORD_W +: WORD_W] = stage_d_q[r];
            end

            if (r > 0) begin : g_chk
                // R5: a valid tap entry moves one round further each edge.
                a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
                    tap_valid[r-1] |=> tap_valid[r]);
            end
        end
    endgenerate

    // Block outputs from the last round and the flag vector.
    always_comb begin
        tap_valid = stage_v_q;
        out_valid = stage_v_q[LAST];
        out_word  = stage_d_q[LAST];
    end

endmodule

// File: tb/mixhash6_test.sv
`timescale 1ns/1ps
module mixhash6_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_word = '0;
    logic         out_valid;
    logic [31:0]  out_word;
    logic [5:0]   tap_valid;
    logic [191:0] tap_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        hist_v [1:6];
    logic [31:0] hist_d [1:6];
    logic [31:0] exp_hold [0:5];

    mixhash6 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word),
        .tap_valid (tap_valid),
        .tap_word  (tap_word)
    );

    always #2.5 clk = ~clk;

    // Model of the first n rounds, written from the R6 table.
    function automatic logic [31:0] model(input logic [31:0] x, input int n);
        logic [31:0] a, b;
        for (int i = 0; i < n; i++) begin
            case (i)
                0: begin a = x + 32'h7ED55D16; b = x << 12; x = a + b; end
                1: begin a = x ^ 32'hC761C23C; b = x >> 19; x = a ^ b; end
                2: begin a = x + 32'h165667B1; b = x << 5;  x = a + b; end
                3: begin a = x + 32'hD3A2646C; b = x << 9;  x = a ^ b; end
                4: begin a = x + 32'hFD7046C5; b = x << 3;  x = a + b; end
                default: begin a = x ^ 32'hB55A4F09; b = x >> 16; x = a ^ b; end
            endcase
        end
        return x;
    endfunction

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model history.
    task automatic check_all();
        logic [5:0]   ev;
        logic [191:0] ew;
        for (int k = 0; k < 6; k++) begin
            if (hist_v[k+1]) exp_hold[k] = model(hist_d[k+1], k + 1);
            ev[k] = hist_v[k+1];
            ew[k*32 +: 32] = exp_hold[k];
        end
        chk("R5 tap_valid", {186'd0, tap_valid}, {186'd0, ev});
        chk("R5 tap_word", tap_word, ew);
        chk("R2 out_valid", {191'd0, out_valid}, {191'd0, hist_v[6]});
        if (hist_v[6]) chk("R3 out_word", {160'd0, out_word}, {160'd0, exp_hold[5]});
        else           chk("R7 out_word held", {160'd0, out_word}, {160'd0, exp_hold[5]});
    endtask

    // One cycle: check what the last edge produced, then drive the next input.
    task automatic step(input logic v, input logic [31:0] d);
        @(negedge clk);
        check_all();
        in_valid = v;
        in_word  = d;
        for (int j = 6; j > 1; j--) begin
            hist_v[j] = hist_v[j-1];
            hist_d[j] = hist_d[j-1];
        end
        hist_v[1] = v;
        hist_d[1] = d;
    endtask

    // R1: reset with a valid word on the input still clears everything.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_word = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {191'd0, out_valid}, 192'd0);
        chk("R1 out_word", {160'd0, out_word}, 192'd0);
        chk("R1 tap_valid", {186'd0, tap_valid}, 192'd0);
        chk("R1 tap_word", tap_word, 192'd0);
        in_valid = 1'b0;
        in_word = '0;
        for (int j = 1; j <= 6; j++) begin
            hist_v[j] = 1'b0;
            hist_d[j] = '0;
        end
        for (int k = 0; k < 6; k++) exp_hold[k] = '0;
        rst_n = 1'b1;
    endtask

    // R6 and R8: literal first-round values for zero and all ones.
    task automatic t_literals();
        step(1'b1, 32'h0000_0000);
        @(posedge clk);
        #1;
        chk("R6 round1 of zero", {160'd0, tap_word[31:0]}, {160'd0, 32'h7ED55D16});
        step(1'b1, 32'hFFFF_FFFF);
        @(posedge clk);
        #1;
        chk("R8 round1 of all ones", {160'd0, tap_word[31:0]}, {160'd0, 32'h7ED54D15});
        step(1'b1, 32'h8000_0000);
        repeat (7) step(1'b0, 32'h0);
    endtask

    // R4: a gap-free burst of distinct words.
    task automatic t_burst();
        logic [31:0] lfsr = 32'h1234_5678;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(1'b1, lfsr);
        end
        repeat (7) step(1'b0, 32'h0);
    endtask

    // R7: bubbles mixed in, with garbage data on invalid cycles.
    task automatic t_bubbles();
        for (int i = 0; i < 20; i++) begin
            if (i % 3 == 0) step(1'b1, 32'h0F0F_0000 + i);
            else            step(1'b0, 32'hA5A5_A5A5 ^ i);
        end
        repeat (8) step(1'b0, 32'hFFFF_FFFF);
    endtask

    // R3 and R8: values near the wrap boundary back to back.
    task automatic t_edges();
        step(1'b1, 32'hFFFF_FFFF);
        step(1'b1, 32'h7FFF_FFFF);
        step(1'b1, 32'h0000_0001);
        step(1'b1, 32'h8130_2AEA);
        repeat (7) step(1'b0, 32'h0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_literals();
        t_burst();
        t_bubbles();
        t_edges();
        t_reset();
        t_burst();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule